// File: doc/BRIEF.md
# Single-Wire UART Transmitter with Collision Guard

This block sends asynchronous serial frames onto a shared line that several nodes drive in wired-AND fashion. While it shifts a frame out on `txd`, it reads the line back through `rxd` and compares the level it drives with the level it sees. A difference means another node is holding the line low. The block then raises a sticky collision flag and, if configured to, drops its own transmit-enable bit, so the frame in progress is abandoned at the next bit boundary.

Bit timing comes from a one-cycle transfer-clock enable (`tick`) supplied by a baud generator outside the block. Transmission can start on the first tick after the transmit condition holds, or it can wait for an edge on the read-back line so the block locks onto a frame another node has begun. The collision sample point is selectable: either the tick itself, or a strobe from an external one-shot timer that sits mid-bit. Software loads a data word with `wr_data`, sets or clears the enable with single-cycle pulses, and clears the collision flag with a write-one pulse.

Top module: `sw_uart_tx`

## Requirements
- R1: A frame on `txd` is a start bit at 0, then the nine data bits with bit 0 first, then a stop bit at 1. Each bit lasts one tick period. `txd` is 1 whenever `busy` is low.
- R2: The transmit condition is `tx_en`=1 with a loaded word pending. With `cfg_edge_start`=0, the start bit begins on the first tick at or after the condition holds, so it begins within one tick period.
- R3: With `cfg_edge_start`=1, the block arms (`busy`=1, `txd`=1) once the condition holds. The start bit then begins on a falling edge of the line level, that is a falling `rxd` when `cfg_inv_pol`=0 and a rising `rxd` when `cfg_inv_pol`=1. An edge that arrives before the condition holds starts nothing.
- R4: `rxd` passes through two flip-flops and is then XORed with `cfg_inv_pol`. Edge detection and comparison both use this line level.
- R5: Collision sampling happens only while a frame is being shifted out. It takes place on `tick` when `cfg_samp_tmr`=0 and on `tmr_strobe` when `cfg_samp_tmr`=1. At each sample the current `txd` is compared with the line level, and a difference sets `coll_flag`.
- R6: `coll_flag` holds its value until a `coll_clr` pulse. A new collision in the same cycle as the clear wins.
- R7: With `cfg_auto_clr`=1, the clock edge that sets `coll_flag` also clears `tx_en`.
- R8: If `tx_en` is 0 at a tick while `busy` is high, the block returns to idle on that tick. `busy` falls, `txd` goes to 1, and no `done` is given.
- R9: `done` is a one-cycle pulse on the tick that ends the stop bit of a completed frame. `busy` is low in that cycle.
- R10: `te_set` sets `tx_en` and `te_clr` clears it. A clear, whether from software or from R7, overrides a set in the same cycle.
- R11: After reset, `txd`=1 and `busy`, `done`, `coll_flag` and `tx_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Transfer-clock enable; one pulse per bit period |
| tmr_strobe | input | 1 | Underflow strobe from the external one-shot timer |
| rxd | input | 1 | Line level read back from the shared bus |
| tx_data | input | 9 | Word to send |
| wr_data | input | 1 | Pulse: load `tx_data` and mark it pending |
| te_set | input | 1 | Pulse: set transmit enable |
| te_clr | input | 1 | Pulse: clear transmit enable |
| coll_clr | input | 1 | Pulse: clear the collision flag |
| cfg_edge_start | input | 1 | 1: start on a line edge; 0: start on a tick |
| cfg_samp_tmr | input | 1 | 1: sample collisions on the timer strobe; 0: on the tick |
| cfg_auto_clr | input | 1 | 1: a collision clears transmit enable |
| cfg_inv_pol | input | 1 | 1: `rxd` is inverted |
| txd | output | 1 | Serial output, idle high |
| tx_en | output | 1 | Transmit-enable state |
| coll_flag | output | 1 | Sticky collision request |
| busy | output | 1 | Armed or shifting |
| done | output | 1 | Frame-complete pulse |

## Verification
The bound checker tests on every cycle the properties that depend only on the relation between outputs. These are: an idle-high line when not busy, a one-cycle `done` that never coincides with `busy`, a sticky flag, no new collision while idle, a cleared enable on an auto-cleared collision, and a return to idle on a tick with the enable low. The bench scenarios cover what the checker cannot. They check the bit order and level of each frame under both polarities and both start modes, and they check that a collision is found in the cases where the other node pulls the line low during a 1 bit and missed where it pulls low during a 0 bit. They also cover the start latency after the condition holds, an edge that arrives before arming and is ignored, and aborts caused by software and by hardware.

// File: rtl/swtx_pkg.sv
// Shared types for the single-wire transmitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package swtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } swtx_state_e;

endpackage

// File: rtl/swtx_rx_front.sv
// Line front end: synchronises the raw read-back input, applies the polarity
// select, and flags a falling edge of the resulting line level.
// Assumes rxd is asynchronous to clk; SYNC_STAGES >= 1.
module swtx_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic inv_pol,
    output logic rx_lvl,
    output logic rx_fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser chain; the variant depends on its length.
    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rxd;
            end
        end
    endgenerate

    // Normalised level: line idle reads as 1 in both polarities.
    assign rx_lvl = sync_q[SYNC_STAGES-1] ^ inv_pol;

    // Previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= rx_lvl;
    end

    assign rx_fall = prev_q & ~rx_lvl;

endmodule

// File: rtl/swtx_shifter.sv
// Frame sequencer: waits for the transmit condition, optionally arms for a
// line edge, then shifts start, data (LSB first) and stop bits out on ticks.
// Assumes tick is a single-cycle enable and go already includes tx_en.
module swtx_shifter
    import swtx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic              edge_start,
    input  logic              rx_fall,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              done,
    output logic              shifting,
    output logic              accept
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    swtx_state_e             state_q, state_d;
    logic [FRAME_BITS-1:0]   sr_q, sr_d;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic                    done_q, done_d;

    // Next-state and datapath decision for one cycle.
    always_comb begin
        state_d = state_q;
        sr_d    = sr_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go && edge_start) begin
                    state_d = ST_ARMED;
                    sr_d    = {1'b1, data, 1'b0};
                    accept  = 1'b1;
                end else if (go && tick) begin
                    state_d = ST_SHIFT;
                    sr_d    = {1'b1, data, 1'b0};
                    cnt_d   = '0;
                    accept  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (tick && !tx_en) begin
                    state_d = ST_IDLE;
                end else if (rx_fall) begin
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!tx_en) begin
                        state_d = ST_IDLE;
                    end else if (cnt_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        sr_d  = {1'b1, sr_q[FRAME_BITS-1:1]};
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sr_q    <= '1;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sr_q    <= sr_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    assign shifting = (state_q == ST_SHIFT);
    assign busy     = (state_q != ST_IDLE);
    assign txd      = shifting ? sr_q[0] : 1'b1;
    assign done     = done_q;

endmodule

// File: rtl/swtx_guard.sv
// Collision guard: picks the sample point, compares driven and read-back
// levels while shifting, keeps the sticky flag, and owns the enable bit.
// Assumes the line level has settled through the synchroniser by the sample.
module swtx_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tmr_strobe,
    input  logic samp_tmr,
    input  logic auto_clr,
    input  logic shifting,
    input  logic txd,
    input  logic rx_lvl,
    input  logic te_set,
    input  logic te_clr,
    input  logic coll_clr,
    output logic coll_flag,
    output logic tx_en
);

    logic sample;
    logic hit;
    logic flag_q;
    logic en_q;

    assign sample = samp_tmr ? tmr_strobe : tick;
    assign hit    = shifting & sample & (txd ^ rx_lvl);

    // Sticky collision flag; a new hit beats the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (coll_clr) flag_q <= 1'b0;
    end

    // Transmit-enable bit; any clear beats a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                           en_q <= 1'b0;
        else if (te_clr || (hit && auto_clr)) en_q <= 1'b0;
        else if (te_set)                      en_q <= 1'b1;
    end

    assign coll_flag = flag_q;
    assign tx_en     = en_q;

endmodule

// File: rtl/sw_uart_tx.sv
// Top level of the single-wire transmitter with collision guard. Holds the
// pending-word flag and ties the line front end, sequencer and guard.
// Assumes tick and tmr_strobe are single-cycle pulses synchronous to clk.
module sw_uart_tx #(
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tmr_strobe,
    input  logic              rxd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              wr_data,
    input  logic              te_set,
    input  logic              te_clr,
    input  logic              coll_clr,
    input  logic              cfg_edge_start,
    input  logic              cfg_samp_tmr,
    input  logic              cfg_auto_clr,
    input  logic              cfg_inv_pol,
    output logic              txd,
    output logic              tx_en,
    output logic              coll_flag,
    output logic              busy,
    output logic              done
);

    logic [DATA_W-1:0] hold_q;
    logic              pend_q;
    logic              accept;
    logic              shifting;
    logic              rx_lvl;
    logic              rx_fall;

    // Holding register and pending flag; a new load beats consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (wr_data) begin
            hold_q <= tx_data;
            pend_q <= 1'b1;
        end else if (accept) begin
            pend_q <= 1'b0;
        end
    end

    swtx_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .inv_pol (cfg_inv_pol),
        .rx_lvl  (rx_lvl),
        .rx_fall (rx_fall)
    );

    swtx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .go         (tx_en & pend_q),
        .edge_start (cfg_edge_start),
        .rx_fall    (rx_fall),
        .tx_en      (tx_en),
        .data       (hold_q),
        .txd        (txd),
        .busy       (busy),
        .done       (done),
        .shifting   (shifting),
        .accept     (accept)
    );

    swtx_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tmr_strobe (tmr_strobe),
        .samp_tmr   (cfg_samp_tmr),
        .auto_clr   (cfg_auto_clr),
        .shifting   (shifting),
        .txd        (txd),
        .rx_lvl     (rx_lvl),
        .te_set     (te_set),
        .te_clr     (te_clr),
        .coll_clr   (coll_clr),
        .coll_flag  (coll_flag),
        .tx_en      (tx_en)
    );

endmodule

// File: rtl/sw_uart_tx_chk.sv
// Property checker for sw_uart_tx, attached through bind below.
// Assumes it observes top-level ports only.
module sw_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic te_clr,
    input logic coll_clr,
    input logic cfg_auto_clr,
    input logic txd,
    input logic tx_en,
    input logic coll_flag,
    input logic busy,
    input logic done
);

    // R1: the line idles high whenever nothing is armed or shifting.
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R9: completion is a single-cycle pulse.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion coincides with return to idle.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: the flag holds until cleared.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_flag && !coll_clr) |=> coll_flag);

    // R5: no collision is raised while idle.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !coll_flag) |=> !coll_flag);

    // R7: an auto-cleared collision leaves the enable low.
    a_r7_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(coll_flag) && $past(cfg_auto_clr)) |-> !tx_en);

    // R8: a tick with the enable low ends any activity without completion.
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_en && tick) |=> (!busy && !done));

    // R10: a software clear always takes effect.
    a_r10_te_clear: assert property (@(posedge clk) disable iff (!rst_n)
        te_clr |=> !tx_en);

endmodule

bind sw_uart_tx sw_uart_tx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .te_clr       (te_clr),
    .coll_clr     (coll_clr),
    .cfg_auto_clr (cfg_auto_clr),
    .txd          (txd),
    .tx_en        (tx_en),
    .coll_flag    (coll_flag),
    .busy         (busy),
    .done         (done)
);

// File: tb/sw_uart_tx_test.sv
module sw_uart_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 9;

    // Vector fields: [15:7] data, [6] edge start, [5] inverted, [4] timer sample,
    // [3:0] frame bit index where the other node pulls low (15 = never).
    localparam logic [15:0] VEC [NVEC] = '{
        {9'h0A5, 1'b0, 1'b0, 1'b0, 4'd15},
        {9'h15A, 1'b0, 1'b0, 1'b0, 4'd3 },
        {9'h1FF, 1'b0, 1'b0, 1'b0, 4'd5 },
        {9'h100, 1'b0, 1'b0, 1'b1, 4'd9 },
        {9'h0F0, 1'b0, 1'b1, 1'b0, 4'd15},
        {9'h033, 1'b0, 1'b1, 1'b1, 4'd1 },
        {9'h1C3, 1'b1, 1'b0, 1'b0, 4'd15},
        {9'h05A, 1'b1, 1'b1, 1'b0, 4'd10},
        {9'h000, 1'b0, 1'b0, 1'b0, 4'd10}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tmr_strobe = 1'b0;
    logic [8:0] tx_data = '0;
    logic       wr_data = 1'b0, te_set = 1'b0, te_clr = 1'b0, coll_clr = 1'b0;
    logic       cfg_edge_start = 1'b0, cfg_samp_tmr = 1'b0;
    logic       cfg_auto_clr = 1'b0, cfg_inv_pol = 1'b0;
    logic       other_n = 1'b1;
    logic       rxd;
    logic       txd, tx_en, coll_flag, busy, done;
    logic [3:0] tcnt = '0;
    int         done_cnt = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;

    // Wired-AND bus seen through the selected polarity.
    assign rxd = cfg_inv_pol ^ (txd & other_n);

    sw_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_strobe(tmr_strobe),
        .rxd(rxd), .tx_data(tx_data), .wr_data(wr_data), .te_set(te_set),
        .te_clr(te_clr), .coll_clr(coll_clr), .cfg_edge_start(cfg_edge_start),
        .cfg_samp_tmr(cfg_samp_tmr), .cfg_auto_clr(cfg_auto_clr),
        .cfg_inv_pol(cfg_inv_pol), .txd(txd), .tx_en(tx_en),
        .coll_flag(coll_flag), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-rate enable every 16 cycles; timer strobe near mid-bit.
    always @(negedge clk) begin
        tcnt       <= tcnt + 4'd1;
        tick       <= (tcnt == 4'd15);
        tmr_strobe <= (tcnt == 4'd7);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && done) done_cnt <= done_cnt + 1;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [8:0] d);
        @(negedge clk); tx_data = d; wr_data = 1'b1;
        @(negedge clk); wr_data = 1'b0;
    endtask

    task automatic pulse_set();
        @(negedge clk); te_set = 1'b1; @(negedge clk); te_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); te_clr = 1'b1; @(negedge clk); te_clr = 1'b0;
    endtask

    task automatic pulse_cclr();
        @(negedge clk); coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0;
    endtask

    task automatic wait_txd_low(output int waited);
        waited = 0;
        while (txd !== 1'b0 && waited < 400) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic run_vec(input int idx);
        logic [8:0]  d;
        logic [3:0]  f;
        logic [10:0] exp_frame, got;
        logic        exp_coll;
        int          w, d0;
        d = VEC[idx][15:7];
        f = VEC[idx][3:0];
        cfg_edge_start = VEC[idx][6];
        cfg_inv_pol    = VEC[idx][5];
        cfg_samp_tmr   = VEC[idx][4];
        cfg_auto_clr   = 1'b0;
        other_n        = 1'b1;
        pulse_cclr();
        cycles(4);
        exp_frame = {1'b1, d, 1'b0};
        exp_coll  = (f <= 4'd10) ? exp_frame[f] : 1'b0;
        d0 = done_cnt;
        pulse_set();
        load(d);
        if (cfg_edge_start) begin
            cycles(20);
            while (!tick) @(negedge clk);
            @(negedge clk);
            other_n = 1'b0;
        end
        wait_txd_low(w);
        for (int k = 0; k < 11; k++) begin
            cycles(2);
            if (k == f) other_n = 1'b0;
            else if (k == 0) other_n = 1'b1;
            cycles(1);
            if (k == f + 1) other_n = 1'b1;
            cycles(5);
            got[k] = txd;
            cycles(8);
        end
        other_n = 1'b1;
        cycles(24);
        check(got == exp_frame, $sformatf("R1 frame vec%0d", idx), 32'(got), 32'(exp_frame));
        check(coll_flag == exp_coll, $sformatf("R5 collision vec%0d", idx),
              32'(coll_flag), 32'(exp_coll));
        check(done_cnt == d0 + 1, $sformatf("R9 done count vec%0d", idx),
              32'(done_cnt - d0), 32'd1);
        check(busy == 1'b0, $sformatf("R9 busy after frame vec%0d", idx), 32'(busy), 32'd0);
    endtask

    initial begin
        int w, d0;
        cycles(3);
        // R11: reset values
        check(txd == 1'b1 && busy == 1'b0 && done == 1'b0, "R11 outputs in reset",
              {29'd0, txd, busy, done}, 32'h4);
        @(negedge clk); rst_n = 1'b1;
        cycles(2);
        check(coll_flag == 1'b0 && tx_en == 1'b0, "R11 flag and enable after reset",
              {30'd0, coll_flag, tx_en}, 32'd0);

        // R1/R3/R4/R5/R6/R9: table of frames over modes and pull positions
        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R6: flag from last vector stays, then clears on pulse
        cycles(50);
        check(coll_flag == 1'b1, "R6 flag held while idle", 32'(coll_flag), 32'd1);
        pulse_cclr();
        @(negedge clk);
        check(coll_flag == 1'b0, "R6 flag cleared by pulse", 32'(coll_flag), 32'd0);

        // R5: line pulled low while idle raises nothing
        cfg_edge_start = 1'b0; cfg_inv_pol = 1'b0; cfg_samp_tmr = 1'b0;
        other_n = 1'b0; cycles(64); other_n = 1'b1; cycles(4);
        check(coll_flag == 1'b0, "R5 no collision while idle", 32'(coll_flag), 32'd0);

        // R2: start within one tick period once condition holds
        while (!tick) @(negedge clk);
        load(9'h0C3);
        w = 0;
        while (txd !== 1'b0 && w < 100) begin @(negedge clk); w++; end
        check(w >= 1 && w <= 17, "R2 start latency", 32'(w), 32'd16);
        cycles(200);

        // R3: edge before arming ignored, edge after arming starts frame
        cfg_edge_start = 1'b1;
        other_n = 1'b0; cycles(4); other_n = 1'b1; cycles(10);
        load(9'h1A5);
        cycles(40);
        check(busy == 1'b1 && txd == 1'b1, "R3 armed and waiting for edge",
              {30'd0, busy, txd}, 32'd3);
        other_n = 1'b0;
        w = 0;
        while (txd !== 1'b0 && w < 40) begin @(negedge clk); w++; end
        other_n = 1'b1;
        check(w <= 5, "R3 start follows edge", 32'(w), 32'd3);
        cycles(200);
        cfg_edge_start = 1'b0;

        // R7/R8: collision with auto clear drops enable and aborts frame
        cfg_auto_clr = 1'b1;
        d0 = done_cnt;
        load(9'h1FF);
        wait_txd_low(w);
        cycles(2);
        other_n = 1'b0;
        w = 0;
        while (!coll_flag && w < 80) begin @(negedge clk); w++; end
        check(coll_flag == 1'b1 && tx_en == 1'b0, "R7 auto clear on collision",
              {30'd0, coll_flag, tx_en}, 32'd2);
        other_n = 1'b1;
        cycles(20);
        check(busy == 1'b0 && txd == 1'b1 && done_cnt == d0, "R8 abort after auto clear",
              {29'd0, busy, txd, 1'(done_cnt != d0)}, 32'd2);
        cfg_auto_clr = 1'b0;
        pulse_cclr();

        // R10/R8: software enable control and mid-frame abort
        pulse_set();
        @(negedge clk);
        check(tx_en == 1'b1, "R10 enable set", 32'(tx_en), 32'd1);
        d0 = done_cnt;
        load(9'h155);
        wait_txd_low(w);
        cycles(40);
        pulse_clr();
        check(tx_en == 1'b0, "R10 enable cleared", 32'(tx_en), 32'd0);
        cycles(20);
        check(busy == 1'b0 && txd == 1'b1 && done_cnt == d0, "R8 software abort",
              {29'd0, busy, txd, 1'(done_cnt != d0)}, 32'd2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule